// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers packets from a low-speed USB differential pair that is sampled by a fast system clock, at least four samples per bit. It waits on an idle line for the first rise of D+, locks its bit timing to the sync field, and strips the NRZI line coding and the stuffed bits. It then packs the data bits into bytes, least significant bit first. Each finished byte goes out on a byte-wide write port with its buffer address, so a block RAM can sit directly behind the block.

When the end-of-packet condition (both lines low) appears at the byte boundary, the block reports one result. The result holds the number of complete bytes, a flag for packets too short to carry a token, and a flag for packets that ran past the buffer size. CRC checking and PID interpretation belong to the logic that reads the buffer.

Top module: `usb_ls_rx`

## Requirements
- R1: During reset and after it, until a packet finishes, `wr_en_o` and `pkt_done_o` are low, and `pkt_len_o`, `pkt_short_o` and `pkt_ovf_o` are zero.
- R2: A rise of D+ on an idle line arms the receiver. If two bit samples in a row read J (D+ low, D- high), or a sample reads SE0 (both lines low), before the sync field is complete, the attempt is dropped as a false start and the receiver waits for the next rise. A false start produces no write and no result.
- R3: The sync field ends at the first two consecutive bit samples that read K (D+ high, D- low). The bit after them is the first data bit.
- R4: NRZI decoding gives a 1 when the sampled D+ level equals the previous bit's level, and a 0 when it differs.
- R5: After six decoded 1s in a row, the next bit is dropped and is not shifted into the byte. A sample reading SE0 is never dropped in this way.
- R6: The count of 1s starts at one, taken from the final K of the sync field. A data byte that begins with five 1s (value 0x1F) is therefore followed by a stuffed bit.
- R7: Bytes are assembled least significant bit first. Each complete byte drives `wr_en_o` high for exactly one cycle, with `wr_addr_o` starting at 0 and rising by one for each byte of the packet.
- R8: End-of-packet is an SE0 reading at the second bit position of a byte. An SE0 that starts on the byte boundary, or one bit late, is accepted. Bits of the unfinished byte are discarded, and `pkt_done_o` pulses for one cycle with `pkt_len_o` equal to the number of bytes written.
- R9: On `pkt_done_o`, `pkt_short_o` is 1 exactly when the packet holds fewer than 3 complete bytes (lengths 0, 1 and 2).
- R10: When byte number BUF_BYTES+1 completes, it is not written. `pkt_done_o` pulses with `pkt_ovf_o`=1 and `pkt_len_o`=BUF_BYTES, and the rest of the packet, up to its SE0, is ignored.
- R11: Every D+ transition restarts the bit-phase counter, and the bit is sampled OSR/2 cycles later. A bit stream whose edges shift by one clock cycle is decoded the same as a stream with regular edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| dp_i | input | 1 | D+ line level (asynchronous) |
| dm_i | input | 1 | D- line level (asynchronous) |
| wr_en_o | output | 1 | One-cycle write strobe for a received byte |
| wr_addr_o | output | $clog2(BUF_BYTES) | Buffer address of the byte |
| wr_data_o | output | 8 | Received byte |
| pkt_done_o | output | 1 | One-cycle pulse at the end of a packet |
| pkt_len_o | output | $clog2(BUF_BYTES+1) | Number of complete bytes written |
| pkt_short_o | output | 1 | Packet shorter than 3 bytes |
| pkt_ovf_o | output | 1 | Packet exceeded BUF_BYTES |

## Verification
The assertions take for granted that reset is held from time zero. They also take for granted that the write strobe and the result pulse never coincide, so a write counter kept beside the block can be cleared on each result and compared with both the address and the reported length. The stimulus never gives the receiver a reason to break that pairing. Every packet ends with a full SE0, then J, then idle, so each result is followed by a clean return to the idle state. Edge jitter is only ever a one-clock delay of a single edge, with the total bit time unchanged, so every sample stays inside its bit.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  // Receive sequencing states.
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SYNC,
    RX_DATA,
    RX_DRAIN
  } rx_state_e;

  // Decoded ones that force a stuffed bit.
  localparam int unsigned LS_STUFF_RUN = 6;

  // Bits per assembled byte.
  localparam int unsigned LS_BYTE_BITS = 8;

  // Single-ended zero: both lines low.
  function automatic logic line_is_se0(input logic p, input logic m);
    return (~p) & (~m);
  endfunction

endpackage

// File: rtl/usbrx_sampler.sv
module usbrx_sampler
  import usbrx_pkg::*;
#(
  parameter int unsigned OSR = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic dp_raw,
  input  logic dm_raw,
  output logic bit_stb,
  output logic bit_dp,
  output logic bit_se0,
  output logic dp_rise,
  output logic line_se0
);

  localparam int unsigned PH_W    = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OSR / 2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

  // Two-stage synchronisers; reset to the idle J state.
  logic [1:0] dp_pipe;
  logic [1:0] dm_pipe;
  logic       dp_s;
  logic       dm_s;
  logic       dp_q;
  logic       line_edge;
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_nxt;

  assign dp_s      = dp_pipe[1];
  assign dm_s      = dm_pipe[1];
  assign line_edge = dp_s ^ dp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_pipe <= 2'b00;
      dm_pipe <= 2'b11;
    end else begin
      dp_pipe <= {dp_pipe[0], dp_raw};
      dm_pipe <= {dm_pipe[0], dm_raw};
    end
  end

  // Phase restarts on every D+ transition, else free-runs modulo OSR.
  always_comb begin
    if (line_edge)
      ph_nxt = '0;
    else if (ph == PH_LAST)
      ph_nxt = '0;
    else
      ph_nxt = ph + PH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_q     <= 1'b0;
      ph       <= '0;
      bit_stb  <= 1'b0;
      bit_dp   <= 1'b0;
      bit_se0  <= 1'b0;
      dp_rise  <= 1'b0;
      line_se0 <= 1'b0;
    end else begin
      dp_q     <= dp_s;
      ph       <= ph_nxt;
      bit_stb  <= (ph_nxt == PH_MID);
      bit_dp   <= dp_s;
      bit_se0  <= line_is_se0(dp_s, dm_s);
      dp_rise  <= dp_s & ~dp_q;
      line_se0 <= line_is_se0(dp_s, dm_s);
    end
  end

endmodule

// File: rtl/usbrx_unstuff.sv
module usbrx_unstuff
  import usbrx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = LS_STUFF_RUN
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic seed,
  input  logic lvl,
  input  logic se0,
  output logic bit_vld,
  output logic bit_val,
  output logic bit_se0
);

  localparam int unsigned RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);

  logic             prev_lvl;
  logic [RUN_W-1:0] run;
  logic             same;

  assign same = (lvl == prev_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      run      <= '0;
      bit_vld  <= 1'b0;
      bit_val  <= 1'b0;
      bit_se0  <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (seed) begin
        // Last sync bit is K (D+ high) and decodes as a 1.
        prev_lvl <= 1'b1;
        run      <= RUN_W'(1);
      end else if (en) begin
        prev_lvl <= lvl;
        bit_se0  <= se0;
        if (!se0 && run == RUN_MAX) begin
          run <= '0;
        end else begin
          bit_vld <= 1'b1;
          bit_val <= same;
          if (!same)
            run <= '0;
          else if (run != RUN_MAX)
            run <= run + RUN_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/usbrx_framer.sv
module usbrx_framer
  import usbrx_pkg::*;
#(
  parameter int unsigned BUF_BYTES  = 8,
  parameter int unsigned SYNC_LIMIT = 12,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          s_dp,
  input  logic          s_se0,
  input  logic          dp_rise,
  input  logic          line_se0,
  input  logic          bit_vld,
  input  logic          bit_val,
  input  logic          bit_se0,
  output logic          data_en,
  output logic          seed,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic [CW-1:0] len,
  output logic          short_f,
  output logic          ovf_f
);

  localparam int unsigned SW = $clog2(SYNC_LIMIT + 1);
  localparam logic [SW-1:0] SYNC_END = SW'(SYNC_LIMIT - 1);
  localparam logic [CW-1:0] FULL     = CW'(BUF_BYTES);
  localparam logic [CW-1:0] MIN_LEN  = CW'(3);
  localparam int unsigned SLW = $clog2(LS_BYTE_BITS);
  localparam logic [SLW-1:0] SLOT_EOP  = SLW'(1);
  localparam logic [SLW-1:0] SLOT_LAST = SLW'(LS_BYTE_BITS - 1);

  rx_state_e      state;
  logic [SW-1:0]  sync_cnt;
  logic           last_k;
  logic [SLW-1:0] slot;
  logic [CW-1:0]  count;
  logic [7:0]     sr;
  logic [7:0]     sr_nxt;

  assign data_en = stb && (state == RX_DATA);
  assign sr_nxt  = {bit_val, sr[7:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      sync_cnt <= '0;
      last_k   <= 1'b0;
      slot     <= '0;
      count    <= '0;
      sr       <= '0;
      seed     <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      len      <= '0;
      short_f  <= 1'b0;
      ovf_f    <= 1'b0;
    end else begin
      seed  <= 1'b0;
      wr_en <= 1'b0;
      done  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (dp_rise) begin
            state    <= RX_SYNC;
            sync_cnt <= '0;
            last_k   <= 1'b0;
          end
        end
        RX_SYNC: begin
          if (stb) begin
            if (s_dp && last_k) begin
              state <= RX_DATA;
              seed  <= 1'b1;
              slot  <= '0;
              count <= '0;
              sr    <= '0;
            end else if (s_se0 || (!s_dp && !last_k) || sync_cnt == SYNC_END) begin
              state <= RX_IDLE;
            end else begin
              sync_cnt <= sync_cnt + SW'(1);
              last_k   <= s_dp;
            end
          end
        end
        RX_DATA: begin
          if (bit_vld) begin
            if (slot == SLOT_EOP && bit_se0) begin
              done    <= 1'b1;
              len     <= count;
              short_f <= (count < MIN_LEN);
              ovf_f   <= 1'b0;
              state   <= RX_IDLE;
            end else begin
              sr   <= sr_nxt;
              slot <= slot + SLW'(1);
              if (slot == SLOT_LAST) begin
                if (count == FULL) begin
                  done    <= 1'b1;
                  len     <= count;
                  short_f <= 1'b0;
                  ovf_f   <= 1'b1;
                  state   <= RX_DRAIN;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= count[AW-1:0];
                  wr_data <= sr_nxt;
                  count   <= count + CW'(1);
                end
              end
            end
          end
        end
        RX_DRAIN: begin
          if (line_se0)
            state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usbrx_pkg::*;
#(
  parameter int unsigned OSR        = 4,
  parameter int unsigned BUF_BYTES  = 8,
  parameter int unsigned SYNC_LIMIT = 12,
  parameter int unsigned STUFF_RUN  = LS_STUFF_RUN,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dp_i,
  input  logic          dm_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          pkt_done_o,
  output logic [CW-1:0] pkt_len_o,
  output logic          pkt_short_o,
  output logic          pkt_ovf_o
);

  logic stb;
  logic s_dp;
  logic s_se0;
  logic dp_rise;
  logic line_se0;
  logic data_en;
  logic seed;
  logic bit_vld;
  logic bit_val;
  logic bit_se0;

  usbrx_sampler #(.OSR(OSR)) u_smp (
    .clk      (clk),
    .rst      (rst),
    .dp_raw   (dp_i),
    .dm_raw   (dm_i),
    .bit_stb  (stb),
    .bit_dp   (s_dp),
    .bit_se0  (s_se0),
    .dp_rise  (dp_rise),
    .line_se0 (line_se0)
  );

  usbrx_unstuff #(.STUFF_RUN(STUFF_RUN)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .en      (data_en),
    .seed    (seed),
    .lvl     (s_dp),
    .se0     (s_se0),
    .bit_vld (bit_vld),
    .bit_val (bit_val),
    .bit_se0 (bit_se0)
  );

  usbrx_framer #(.BUF_BYTES(BUF_BYTES), .SYNC_LIMIT(SYNC_LIMIT)) u_frm (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .s_dp     (s_dp),
    .s_se0    (s_se0),
    .dp_rise  (dp_rise),
    .line_se0 (line_se0),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .bit_se0  (bit_se0),
    .data_en  (data_en),
    .seed     (seed),
    .wr_en    (wr_en_o),
    .wr_addr  (wr_addr_o),
    .wr_data  (wr_data_o),
    .done     (pkt_done_o),
    .len      (pkt_len_o),
    .short_f  (pkt_short_o),
    .ovf_f    (pkt_ovf_o)
  );

endmodule

// File: rtl/usbrx_checker.sv
module usbrx_checker #(
  parameter int unsigned BUF_BYTES = 8,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned CW = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          done,
  input logic [CW-1:0] len,
  input logic          ovf
);

  // Bytes written since the last packet result.
  logic [CW-1:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      wr_cnt <= '0;
    else if (done)
      wr_cnt <= '0;
    else if (wr_en)
      wr_cnt <= wr_cnt + CW'(1);
  end

  p_wr_single_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_addr_seq_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (CW'(wr_addr) == wr_cnt));

  p_len_match_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !ovf) |-> (len == wr_cnt));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_nowr_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);

  p_ovf_full_r10: assert property (@(posedge clk) disable iff (rst)
    (done && ovf) |-> (len == CW'(BUF_BYTES) && wr_cnt == CW'(BUF_BYTES)));

endmodule

bind usb_ls_rx usbrx_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en_o),
  .wr_addr (wr_addr_o),
  .done    (pkt_done_o),
  .len     (pkt_len_o),
  .ovf     (pkt_ovf_o)
);

// File: tb/sim_usb_ls_rx.sv
module sim_usb_ls_rx;
  localparam int OSR = 4;
  localparam int NB  = 8;
  localparam int AW  = $clog2(NB);
  localparam int CW  = $clog2(NB + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dp  = 1'b0;
  logic dm  = 1'b1;
  always #2 clk = ~clk;

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          done;
  logic [CW-1:0] len;
  logic          short_f;
  logic          ovf_f;

  usb_ls_rx #(.OSR(OSR), .BUF_BYTES(NB)) u0 (
    .clk(clk), .rst(rst), .dp_i(dp), .dm_i(dm),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .pkt_done_o(done), .pkt_len_o(len), .pkt_short_o(short_f), .pkt_ovf_o(ovf_f)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] got [0:NB-1];
  int n_wr, n_done, last_len;
  bit last_short, last_ovf;

  // Symbol codes: 0 = J, 1 = K, 2 = SE0
  logic [1:0] sym [0:1023];
  int ns;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        got[wr_addr] = wr_data;
        n_wr++;
      end
      if (done) begin
        n_done++;
        last_len   = int'(len);
        last_short = short_f;
        last_ovf   = ovf_f;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_wr = 0;
    n_done = 0;
    last_len = 0;
    last_short = 0;
    last_ovf = 0;
    for (int k = 0; k < NB; k++) got[k] = 8'h00;
  endtask

  task automatic put(input logic p, input logic m, input int cyc);
    dp = p;
    dm = m;
    repeat (cyc) @(posedge clk);
    #1;
  endtask

  task automatic put_sym(input logic [1:0] s, input int cyc);
    if (s == 2'd2) put(1'b0, 1'b0, cyc);
    else put(s[0], ~s[0], cyc);
  endtask

  function automatic logic [7:0] pat_byte(input int pat, input int k);
    case (pat)
      0: return 8'hFF;
      1: return 8'h00;
      2: return 8'(k * 29 + 8'h5A);
      default: return (k == 0) ? 8'h1F : 8'(8'hE0 | k);
    endcase
  endfunction

  task automatic drive_syms(input bit skew);
    logic [1:0] prev;
    prev = 2'd0;
    for (int i = 0; i < ns; i++) begin
      if (skew && (i % 2 == 1) && sym[i] != prev) begin
        put_sym(prev, 1);
        put_sym(sym[i], OSR - 1);
      end else begin
        put_sym(sym[i], OSR);
      end
      prev = sym[i];
    end
  endtask

  task automatic send(input int n, input int pat, input bit late, input bit skew);
    int ones;
    logic cur;
    logic [7:0] v;
    ones = 0;
    cur = 1'b0;
    ns = 0;
    for (int i = 0; i < 8; i++) begin
      if (i != 7) cur = ~cur;
      sym[ns] = {1'b0, cur}; ns++;
      ones = (i == 7) ? ones + 1 : 0;
    end
    for (int k = 0; k < n; k++) begin
      v = pat_byte(pat, k);
      for (int i = 0; i < 8; i++) begin
        if (!v[i]) cur = ~cur;
        sym[ns] = {1'b0, cur}; ns++;
        ones = v[i] ? ones + 1 : 0;
        if (ones == 6) begin
          cur = ~cur;
          sym[ns] = {1'b0, cur}; ns++;
          ones = 0;
        end
      end
    end
    if (late) begin
      cur = ~cur;
      sym[ns] = {1'b0, cur}; ns++;
    end
    sym[ns] = 2'd2; ns++;
    sym[ns] = 2'd2; ns++;
    for (int i = 0; i < 8; i++) begin
      sym[ns] = 2'd0; ns++;
    end
    drive_syms(skew);
  endtask

  task automatic send_raw_false(input int kind);
    ns = 0;
    case (kind)
      0: begin
        sym[ns] = 2'd1; ns++;
      end
      1: begin
        for (int i = 0; i < 8; i++) begin
          sym[ns] = (i % 2 == 0) ? 2'd1 : 2'd0; ns++;
        end
      end
      default: begin
        sym[ns] = 2'd1; ns++;
        sym[ns] = 2'd0; ns++;
        sym[ns] = 2'd1; ns++;
        sym[ns] = 2'd2; ns++;
        sym[ns] = 2'd2; ns++;
      end
    endcase
    for (int i = 0; i < 10; i++) begin
      sym[ns] = 2'd0; ns++;
    end
    drive_syms(1'b0);
  endtask

  task automatic check_pkt(input int n, input int pat, input bit late, input bit skew);
    int exp_n;
    int mism;
    exp_n = (n > NB) ? NB : n;
    mism = 0;
    chk(n_done == 1, "R3 packet accepted after sync, result count", n_done, 1);
    chk(last_len == exp_n, late ? "R8 late EOP length" : "R8 EOP length", last_len, exp_n);
    chk(last_short == (n < 3), "R9 short flag", int'(last_short), int'(n < 3));
    chk(last_ovf == (n > NB), "R10 overflow flag", int'(last_ovf), int'(n > NB));
    chk(n_wr == exp_n, "R7 write count", n_wr, exp_n);
    for (int k = 0; k < exp_n; k++)
      if (got[k] != pat_byte(pat, k)) mism++;
    if (skew)
      chk(mism == 0, "R11 data with shifted edges", mism, 0);
    else if (pat == 0)
      chk(mism == 0, "R5 unstuffed data", mism, 0);
    else if (pat == 1)
      chk(mism == 0, "R4 NRZI data", mism, 0);
    else if (pat == 2)
      chk(mism == 0, "R7 LSB-first data", mism, 0);
    else
      chk(mism == 0, "R6 run seeded from sync", mism, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R8 actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clear_mon();
    repeat (5) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    chk(wr_en == 0 && done == 0, "R1 strobes in reset", int'(wr_en) + int'(done), 0);
    chk(len == 0 && short_f == 0 && ovf_f == 0, "R1 result fields in reset", int'(len), 0);
    rst = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    chk(n_wr == 0 && n_done == 0 && len == 0, "R1 quiet after reset", n_wr + n_done, 0);

    // R2: false starts produce nothing, receiver recovers afterwards
    for (int kind = 0; kind < 3; kind++) begin
      clear_mon();
      send_raw_false(kind);
      chk(n_wr == 0 && n_done == 0, "R2 false start ignored", n_wr + n_done, 0);
      clear_mon();
      send(4, 2, 1'b0, 1'b0);
      check_pkt(4, 2, 1'b0, 1'b0);
    end

    // Sweep over length, pattern, EOP delay and edge shift
    for (int pat = 0; pat < 4; pat++)
      for (int n = 0; n <= NB + 2; n++)
        for (int late = 0; late < 2; late++)
          for (int skew = 0; skew < 2; skew++) begin
            clear_mon();
            send(n, pat, late[0], skew[0]);
            check_pkt(n, pat, late[0], skew[0]);
          end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule